// File: doc/BRIEF.md
# Wrapper Instruction Register with One-Hot Decode

This block is the serial instruction register of a core test wrapper. A test controller enters a new instruction code one bit at a time. While it does so, the block shifts out the code that is currently in force. An update strobe then commits the new code to a hold register. The hold register is decoded into two one-hot select buses. One bus serves the standard wrapper instructions, which are bypass, external test and internal test. The other bus serves user-defined instructions, which here are three memory self-test programs. Downstream data registers and the serial-path multiplexer use these select lines to choose which register is active.

The controller drives three strobes: capture, shift and update. They are qualified by an instruction-register select input and sampled on rising clock edges. A typical sequence is one capture cycle, then one shift cycle per code bit, then one update cycle. The instruction set is set by two parameters, the number of standard instructions and the number of user instructions. Standard codes come first in the code space, starting at zero. User codes follow them.

Top module: `wrapper_instr_reg`

## Requirements
- R1: When `rst` is high at a rising edge, both the shift stage and the hold register are cleared to code 0 (bypass) and `ser_out` is cleared to 0. Afterwards `std_sel` is 3'b001 and `usr_sel` is 3'b000.
- R2: Codes are assigned by list position. Code 0 is bypass (`std_sel` bit 0), code 1 is external test (bit 1) and code 2 is internal test (bit 2). Codes 3, 4 and 5 are user instructions 1, 2 and 3, on `usr_sel` bits 0, 1 and 2.
- R3: The code width is the smallest width that holds the instruction count, which is 3 bits for six instructions. Exactly 3 shift cycles replace the whole code.
- R4: Shifting is least-significant bit first. `ser_in` is sampled on each shift edge, so code 1 is entered as 1,0,0 and code 5 as 1,0,1.
- R5: A capture loads the hold register into the shift stage. After the k-th shift edge that follows, `ser_out` equals bit k-1 of the previously latched code.
- R6: After an update, exactly one bit across `std_sel` and `usr_sel` is high, and it is the bit of the latched code.
- R7: While `ir_sel` is low, capture, shift and update have no effect. The hold register, the select buses and `ser_out` do not change.
- R8: A latched code of 6 or 7 asserts `std_sel` bit 0 (bypass) and clears every other select bit.
- R9: The select buses change only on an update edge. They are stable throughout capture and shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Wrapper clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ir_sel | input | 1 | Instruction-register select; qualifies all strobes |
| capture_en | input | 1 | Capture strobe: copy hold register into shift stage |
| shift_en | input | 1 | Shift strobe: move one bit in and one bit out |
| update_en | input | 1 | Update strobe: commit shift stage to hold register |
| ser_in | input | 1 | Serial instruction data in, LSB first |
| ser_out | output | 1 | Serial data out, previous code LSB first |
| std_sel | output | 3 | One-hot select for bypass, external test, internal test |
| usr_sel | output | 3 | One-hot select for user instructions 1 to 3 |

## Verification
The assertions assume that the controller raises at most one strobe per cycle, with capture taking priority if several are raised. They also assume that a shift burst always follows a capture, so that the serial output replays the latched code. The stimulus keeps to this. Every sequence raises capture, shift and update in separate cycles with `ir_sel` high. Ignored strobes are exercised only as whole sequences with `ir_sel` low. Reset is applied only between sequences.

// File: rtl/wir_pkg.sv
package wir_pkg;

    localparam int DEF_NUM_STD = 3;
    localparam int DEF_NUM_USR = 3;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2,
        OP_UPDATE  = 2'd3
    } ir_op_e;

    // Capture wins over shift, shift over update; nothing happens unselected.
    function automatic ir_op_e pick_op(input logic sel, input logic cap,
                                       input logic shf, input logic upd);
        ir_op_e op;
        op = OP_IDLE;
        if (sel) begin
            if (cap)      op = OP_CAPTURE;
            else if (shf) op = OP_SHIFT;
            else if (upd) op = OP_UPDATE;
        end
        return op;
    endfunction

endpackage

// File: rtl/wir_shift_stage.sv
module wir_shift_stage
    import wir_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  ir_op_e            op,
    input  logic              ser_in,
    input  logic [CODE_W-1:0] hold_code,
    output logic [CODE_W-1:0] stage_q,
    output logic              ser_out
);

    logic [CODE_W-1:0] stage_d;

    always_comb begin
        stage_d = stage_q;
        case (op)
            OP_CAPTURE: stage_d = hold_code;
            OP_SHIFT:   stage_d = {ser_in, stage_q[CODE_W-1:1]};
            default:    stage_d = stage_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            ser_out <= 1'b0;
        end else begin
            stage_q <= stage_d;
            if (op == OP_SHIFT) ser_out <= stage_q[0];
        end
    end

    AST_IDLE_STAGE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE || op == OP_UPDATE) |=> $stable(stage_q)); // R7
    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CAPTURE) |=> stage_q == $past(hold_code)); // R5

endmodule

// File: rtl/wir_hold_reg.sv
module wir_hold_reg
    import wir_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  ir_op_e            op,
    input  logic [CODE_W-1:0] stage_q,
    output logic [CODE_W-1:0] hold_q
);

    always_ff @(posedge clk) begin
        if (rst)                  hold_q <= '0;
        else if (op == OP_UPDATE) hold_q <= stage_q;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (op != OP_UPDATE) |=> $stable(hold_q)); // R9
    AST_HOLD_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (op == OP_UPDATE) |=> hold_q == $past(stage_q)); // R6

endmodule

// File: rtl/wir_decoder.sv
module wir_decoder #(
    parameter int NUM_STD = 3,
    parameter int NUM_USR = 3,
    parameter int CODE_W  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CODE_W-1:0]  code,
    output logic [NUM_STD-1:0] std_sel,
    output logic [NUM_USR-1:0] usr_sel
);

    localparam int TOTAL = NUM_STD + NUM_USR;

    logic   unknown;
    assign unknown = (int'(code) >= TOTAL);

    for (genvar g = 0; g < NUM_STD; g++) begin : g_std
        if (g == 0) begin : g_byp
            assign std_sel[g] = (int'(code) == g) || unknown;
        end else begin : g_oth
            assign std_sel[g] = (int'(code) == g);
        end
    end

    for (genvar u = 0; u < NUM_USR; u++) begin : g_usr
        assign usr_sel[u] = (int'(code) == NUM_STD + u);
    end

    AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $countones({usr_sel, std_sel}) == 1); // R6
    AST_UNKNOWN_BYPASS: assert property (@(posedge clk) disable iff (rst)
        unknown |-> (std_sel[0] && usr_sel == '0)); // R8

endmodule

// File: rtl/wrapper_instr_reg.sv
module wrapper_instr_reg
    import wir_pkg::*;
#(
    parameter int NUM_STD = DEF_NUM_STD,
    parameter int NUM_USR = DEF_NUM_USR
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ir_sel,
    input  logic               capture_en,
    input  logic               shift_en,
    input  logic               update_en,
    input  logic               ser_in,
    output logic               ser_out,
    output logic [NUM_STD-1:0] std_sel,
    output logic [NUM_USR-1:0] usr_sel
);

    localparam int TOTAL  = NUM_STD + NUM_USR;
    localparam int CODE_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

    ir_op_e            op;
    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] hold_q;

    assign op = pick_op(ir_sel, capture_en, shift_en, update_en);

    wir_shift_stage #(.CODE_W(CODE_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .ser_in    (ser_in),
        .hold_code (hold_q),
        .stage_q   (stage_q),
        .ser_out   (ser_out)
    );

    wir_hold_reg #(.CODE_W(CODE_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .stage_q (stage_q),
        .hold_q  (hold_q)
    );

    wir_decoder #(.NUM_STD(NUM_STD), .NUM_USR(NUM_USR), .CODE_W(CODE_W)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .code    (hold_q),
        .std_sel (std_sel),
        .usr_sel (usr_sel)
    );

    AST_RESET_BYPASS: assert property (@(posedge clk)
        rst |=> (std_sel == NUM_STD'(1) && usr_sel == '0 && !ser_out)); // R1
    AST_UNSELECTED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ir_sel |=> ($stable(std_sel) && $stable(usr_sel) && $stable(ser_out))); // R7
    AST_SEROUT_LSB: assert property (@(posedge clk) disable iff (rst)
        (ir_sel && shift_en && !capture_en) |=> ser_out == $past(stage_q[0])); // R5
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(ir_sel && update_en) |=> ($stable(std_sel) && $stable(usr_sel))); // R9

endmodule

// File: tb/wrapper_instr_reg_bench.sv
module wrapper_instr_reg_bench;

    localparam int NS = 3;
    localparam int NU = 3;
    localparam int W  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ir_sel = 1'b0, capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0;
    logic ser_in = 1'b0;
    logic ser_out;
    logic [NS-1:0] std_sel;
    logic [NU-1:0] usr_sel;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] prev = '0;

    always #10 clk = ~clk;

    wrapper_instr_reg #(.NUM_STD(NS), .NUM_USR(NU)) u_wrapper_instr_reg (
        .clk(clk), .rst(rst), .ir_sel(ir_sel), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en), .ser_in(ser_in),
        .ser_out(ser_out), .std_sel(std_sel), .usr_sel(usr_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_std(input int code);
        if (code < NS) return 1 << code;
        if (code >= NS + NU) return 1;
        return 0;
    endfunction

    function automatic int exp_usr(input int code);
        if (code >= NS && code < NS + NU) return 1 << (code - NS);
        return 0;
    endfunction

    // R2 R3 R4 R5 R6 R8 R9: full capture / shift / update sequence
    task automatic run_code(input logic [W-1:0] code, input string req);
        @(negedge clk);
        ir_sel = 1'b1; capture_en = 1'b1;
        @(negedge clk);
        capture_en = 1'b0; shift_en = 1'b1;
        for (int i = 0; i < W; i++) begin
            ser_in = code[i];
            @(negedge clk);
            chk(ser_out == prev[i], "R5 serial replay", int'(ser_out), int'(prev[i]));
            chk(std_sel == exp_std(prev) && usr_sel == exp_usr(prev), "R9 stable during shift",
                int'({usr_sel, std_sel}), (exp_usr(prev) << NS) | exp_std(prev));
        end
        shift_en = 1'b0; ser_in = 1'b0; update_en = 1'b1;
        @(negedge clk);
        update_en = 1'b0; ir_sel = 1'b0;
        chk(int'(std_sel) == exp_std(code), {req, " std_sel (R3 R4)"}, int'(std_sel), exp_std(code));
        chk(int'(usr_sel) == exp_usr(code), {req, " usr_sel (R3 R4)"}, int'(usr_sel), exp_usr(code));
        chk($countones({usr_sel, std_sel}) == 1, "R6 one hot", $countones({usr_sel, std_sel}), 1);
        prev = code;
    endtask

    // R7: strobes with ir_sel low
    task automatic ignored_strobes(input logic [W-1:0] code);
        logic [NS-1:0] s0;
        logic [NU-1:0] u0;
        logic o0;
        s0 = std_sel; u0 = usr_sel; o0 = ser_out;
        @(negedge clk);
        ir_sel = 1'b0; capture_en = 1'b1;
        @(negedge clk);
        capture_en = 1'b0; shift_en = 1'b1;
        for (int i = 0; i < W; i++) begin
            ser_in = code[i];
            @(negedge clk);
            chk(ser_out == o0, "R7 ser_out quiet", int'(ser_out), int'(o0));
        end
        shift_en = 1'b0; update_en = 1'b1;
        @(negedge clk);
        update_en = 1'b0; ser_in = 1'b0;
        chk(std_sel == s0 && usr_sel == u0, "R7 selects unchanged",
            int'({usr_sel, std_sel}), int'({u0, s0}));
    endtask

    // R1: reset state
    task automatic check_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(int'(std_sel) == 1, "R1 std_sel bypass", int'(std_sel), 1);
        chk(usr_sel == '0, "R1 usr_sel clear", int'(usr_sel), 0);
        chk(ser_out == 1'b0, "R1 ser_out low", int'(ser_out), 0);
        prev = '0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check_reset();
        run_code(3'd0, "R2 bypass");
        run_code(3'd1, "R2 external test");
        run_code(3'd2, "R2 internal test");
        run_code(3'd3, "R2 user 1");
        run_code(3'd4, "R2 user 2");
        run_code(3'd5, "R2 user 3");
        ignored_strobes(3'd2);
        run_code(3'd6, "R8 code 6");
        run_code(3'd7, "R8 code 7");
        run_code(3'd4, "R2 user 2 again");
        check_reset();
        run_code(3'd1, "R2 after reset");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule